// File: doc/BRIEF.md
# Spread-Spectrum Frequency-Offset Profile Generator

This block drives the fractional divider of a clock synthesiser with a signed frequency-offset word. The word follows a triangular profile, so the synthesised clock sweeps slowly around its nominal frequency and its spectral energy spreads over a band instead of sitting in one line. Two profile shapes are available. Down-spread sweeps from nominal to below nominal and back. Centre-spread swings symmetrically above and below nominal. The depth is picked from a fixed set of percentages by a small code. A one-clock flag marks every turning point of the triangle.

The settings come from one of two sources, chosen by a select input. With the select clear, the block uses a fixed 0.80 % down-spread, and its enable comes from a pin sampled during reset. With the select set, the shape, depth code and enable come from register bits. Two frequency-select pins are also captured during reset and held for read-back. The offset word is in units of 0.01 % divided by 2^RAMP_LOG2. An update occurs once every DIV clocks, where DIV = floor(REF_KHZ / (MOD_KHZ·2·2^RAMP_LOG2)). MOD_KHZ is the modulation rate and is meant to lie between 20 and 40.

Top module: `ssmod_profile`

## Requirements
- R1: While rstN is low, freqOffset reads 0 and peakFlag reads 0. After reset, the first non-zero offset is negative, because the ramp always starts downward.
- R2: In down-spread (regKind = 0), freqOffset moves between 0 and −A·N and is never positive. A is the depth in hundredths of a percent and N = 2^RAMP_LOG2.
- R3: In centre-spread (regKind = 1), freqOffset swings between −A·N/2 and +A·N/2.
- R4: Down-spread codes 0 to 8 select A = 60, 80, 100, 125, 150, 175, 200, 250 and 300. Centre-spread codes 0 to 6 select A = 30, 40, 50, 70, 100, 120 and 150. Any other code selects A = 0, so the offset stays at 0.
- R5: Each update changes the offset by exactly ±A, once every DIV clocks, and the offset holds between updates. peakFlag is high for one clock each time a turning limit is reached, and consecutive peaks lie N·DIV clocks apart.
- R6: When the effective enable goes low, freqOffset is 0 from the next clock.
- R7: With swSel = 0, the profile is a 0.80 % down-spread whose enable is the value pinSpreadEn had in the last reset cycle. Later changes on pinSpreadEn have no effect. With swSel = 1, regKind, regCode and regSpreadEn control the profile.
- R8: fsReadback holds the value pinFs had in the last reset cycle. It does not follow later changes on pinFs.
- R9: A change of shape or depth takes effect only at the update that starts from a zero offset. Until then, the ramp in progress keeps its old step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous active-low reset; pins are sampled while it is low |
| pinFs | input | 2 | Frequency-select pins, captured during reset |
| pinSpreadEn | input | 1 | Spread enable pin, captured during reset |
| swSel | input | 1 | 0: fixed default profile and pin enable; 1: register control |
| regKind | input | 1 | Register shape: 0 down, 1 centre |
| regCode | input | 4 | Register depth code |
| regSpreadEn | input | 1 | Register spread enable |
| freqOffset | output | OFS_W | Signed frequency-offset word |
| peakFlag | output | 1 | One-clock pulse at each turning point |
| fsReadback | output | 2 | Captured frequency-select pins |

## Verification
The hardest case to reach from the ports is a settings change that lands in the middle of a ramp. To show that the change is deferred, the old step size must be seen on every update up to the return to zero, and the new step only after it. The stimulus enables a 1.00 % down-spread and waits until the offset has passed −1000, which means the ramp is heading down. It then writes the 3.00 % code and follows each change of the offset until zero and one update beyond it. Each row of the code table is also measured over a full period: the extremes, the size of every step and the spacing of the peaks.

// File: rtl/ssmod_pkg.sv
package ssmod_pkg;
  localparam int CODE_W = 4;
  localparam int AMT_W  = 9;
  localparam int AMT_MAX = 300;
  localparam logic [CODE_W-1:0] DEFAULT_CODE = 4'd1;

  typedef enum logic {SPREAD_DOWN = 1'b0, SPREAD_CENTER = 1'b1} spreadKind_e;

  typedef struct packed {
    spreadKind_e           kind;
    logic [CODE_W-1:0]     code;
  } spreadCfg_t;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic              tick;
    logic              clear;
    spreadKind_e       kind;
    logic [AMT_W-1:0]  step;
  } ctrl_t;

  // depth in hundredths of a percent; unlisted codes give no spread
  function automatic logic [AMT_W-1:0] amountOf(spreadCfg_t c);
    logic [AMT_W-1:0] a;
    a = '0;
    if (c.kind == SPREAD_DOWN) begin
      case (c.code)
        4'd0: a = 9'd60;
        4'd1: a = 9'd80;
        4'd2: a = 9'd100;
        4'd3: a = 9'd125;
        4'd4: a = 9'd150;
        4'd5: a = 9'd175;
        4'd6: a = 9'd200;
        4'd7: a = 9'd250;
        4'd8: a = 9'd300;
        default: a = '0;
      endcase
    end else begin
      case (c.code)
        4'd0: a = 9'd30;
        4'd1: a = 9'd40;
        4'd2: a = 9'd50;
        4'd3: a = 9'd70;
        4'd4: a = 9'd100;
        4'd5: a = 9'd120;
        4'd6: a = 9'd150;
        default: a = '0;
      endcase
    end
    return a;
  endfunction
endpackage

// File: rtl/ssmod_ctrl.sv
module ssmod_ctrl
  import ssmod_pkg::*;
#(
  parameter int REF_KHZ   = 14318,
  parameter int MOD_KHZ   = 30,
  parameter int RAMP_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pinFs,
  input  logic              pinSpreadEn,
  input  logic              swSel,
  input  logic              regKind,
  input  logic [CODE_W-1:0] regCode,
  input  logic              regSpreadEn,
  input  logic              atZero,
  output ctrl_t             ctrlBus,
  output logic [1:0]        fsReadback
);
  localparam int RAMP_STEPS = 1 << RAMP_LOG2;
  localparam int DIV_RAW    = REF_KHZ / (MOD_KHZ * 2 * RAMP_STEPS);
  localparam int DIV        = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int DIV_W      = $clog2(DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [1:0]       fsLatch;
  logic             enLatch;
  spreadCfg_t       wantCfg, activeCfg, curCfg;
  logic             wantEn, tick, applyNow, loadCfg;

  assign tick     = (divCnt == DIV_LAST);
  assign wantCfg  = swSel ? '{kind: spreadKind_e'(regKind), code: regCode}
                          : '{kind: SPREAD_DOWN, code: DEFAULT_CODE};
  assign wantEn   = swSel ? regSpreadEn : enLatch;
  assign applyNow = tick && atZero;
  assign loadCfg  = !wantEn || applyNow;
  assign curCfg   = applyNow ? wantCfg : activeCfg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsLatch   <= pinFs;
      enLatch   <= pinSpreadEn;
      divCnt    <= '0;
      activeCfg <= '{kind: SPREAD_DOWN, code: DEFAULT_CODE};
    end else begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (loadCfg) activeCfg <= wantCfg;
    end
  end

  always_comb begin
    ctrlBus.tick  = tick;
    ctrlBus.clear = !wantEn;
    ctrlBus.kind  = curCfg.kind;
    ctrlBus.step  = amountOf(curCfg);
  end

  assign fsReadback = fsLatch;
endmodule

// File: rtl/ssmod_ramp.sv
module ssmod_ramp
  import ssmod_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int RAMP_LOG2 = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_t                   ctrlBus,
  output logic signed [OFS_W-1:0] freqOffset,
  output logic                    peakFlag,
  output logic                    atZero
);
  localparam int HALF_SH = RAMP_LOG2 - 1;

  logic signed [OFS_W-1:0] acc, stepS, lowLim, highLim, sum, nxt;
  logic goingUp, clampHit;

  always_comb begin
    stepS = OFS_W'(ctrlBus.step);
    if (ctrlBus.kind == SPREAD_CENTER) begin
      highLim = stepS <<< HALF_SH;
      lowLim  = -highLim;
    end else begin
      highLim = '0;
      lowLim  = -(stepS <<< RAMP_LOG2);
    end
    sum      = goingUp ? acc + stepS : acc - stepS;
    clampHit = goingUp ? (sum >= highLim) : (sum <= lowLim);
    if (clampHit) nxt = goingUp ? highLim : lowLim;
    else          nxt = sum;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrlBus.clear) begin
      acc      <= '0;
      goingUp  <= 1'b0;
      peakFlag <= 1'b0;
    end else begin
      peakFlag <= 1'b0;
      if (ctrlBus.tick && ctrlBus.step != '0) begin
        acc      <= nxt;
        peakFlag <= clampHit;
        if (clampHit) goingUp <= !goingUp;
      end
    end
  end

  assign freqOffset = acc;
  assign atZero     = (acc == '0);
endmodule

// File: rtl/ssmod_profile.sv
module ssmod_profile
  import ssmod_pkg::*;
#(
  parameter int REF_KHZ   = 14318,
  parameter int MOD_KHZ   = 30,
  parameter int RAMP_LOG2 = 5,
  parameter int OFS_W     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              pinFs,
  input  logic                    pinSpreadEn,
  input  logic                    swSel,
  input  logic                    regKind,
  input  logic [3:0]              regCode,
  input  logic                    regSpreadEn,
  output logic signed [OFS_W-1:0] freqOffset,
  output logic                    peakFlag,
  output logic [1:0]              fsReadback
);
  ctrl_t ctrlBus;
  logic  atZero;

  ssmod_ctrl #(.REF_KHZ(REF_KHZ), .MOD_KHZ(MOD_KHZ), .RAMP_LOG2(RAMP_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinFs(pinFs), .pinSpreadEn(pinSpreadEn),
    .swSel(swSel), .regKind(regKind), .regCode(regCode), .regSpreadEn(regSpreadEn),
    .atZero(atZero), .ctrlBus(ctrlBus), .fsReadback(fsReadback)
  );

  ssmod_ramp #(.OFS_W(OFS_W), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus),
    .freqOffset(freqOffset), .peakFlag(peakFlag), .atZero(atZero)
  );
endmodule

// File: rtl/ssmod_profile_chk.sv
module ssmod_profile_chk
  import ssmod_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int RAMP_LOG2 = 5
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    swSel,
  input logic                    regSpreadEn,
  input logic signed [OFS_W-1:0] freqOffset,
  input logic                    peakFlag,
  input logic [1:0]              fsReadback,
  input ctrl_t                   ctrlBus
);
  localparam logic signed [OFS_W-1:0] MAXMAG = OFS_W'(AMT_MAX << RAMP_LOG2);

  logic signed [OFS_W-1:0] stepS;
  assign stepS = OFS_W'(ctrlBus.step);

  // R2: down shape never rises above nominal
  p_down_nonpos_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.tick && !ctrlBus.clear && ctrlBus.kind == SPREAD_DOWN) |=> (freqOffset <= 0));

  // R4: no code drives the offset beyond the deepest setting
  p_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (freqOffset <= MAXMAG) && (freqOffset >= -MAXMAG));

  // R5: an update moves by at most one step
  p_step_size_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.tick && !ctrlBus.clear) |=>
      ((freqOffset - $past(freqOffset) <= $past(stepS)) &&
       (freqOffset - $past(freqOffset) >= -$past(stepS))));

  // R5: offset holds between updates
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBus.tick && !ctrlBus.clear) |=> $stable(freqOffset));

  // R5: turning-point flag is a single-clock pulse
  p_peak_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    peakFlag |=> !peakFlag);

  // R6: register disable zeroes the offset on the next clock
  p_disable_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (swSel && !regSpreadEn) |=> (freqOffset == 0));

  // R8: captured frequency-select value is held after reset
  p_readback_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(fsReadback));
endmodule

bind ssmod_profile ssmod_profile_chk #(.OFS_W(OFS_W), .RAMP_LOG2(RAMP_LOG2)) u_chk (
  .clk(clk), .rstN(rstN), .swSel(swSel), .regSpreadEn(regSpreadEn),
  .freqOffset(freqOffset), .peakFlag(peakFlag), .fsReadback(fsReadback),
  .ctrlBus(ctrlBus)
);

// File: tb/ssmod_profile_tb.sv
module ssmod_profile_tb;
  localparam int REF_KHZ   = 14318;
  localparam int MOD_KHZ   = 30;
  localparam int RAMP_LOG2 = 5;
  localparam int OFS_W     = 16;
  localparam int N         = 1 << RAMP_LOG2;
  localparam int DIV       = REF_KHZ / (MOD_KHZ * 2 * N);
  localparam int PER       = N * DIV;  // clocks between peaks

  // {kind, code[3:0], amount[8:0]} with amount in hundredths of a percent
  localparam int NVEC = 19;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 4'd0, 9'd60},  {1'b0, 4'd1, 9'd80},  {1'b0, 4'd2, 9'd100},
    {1'b0, 4'd3, 9'd125}, {1'b0, 4'd4, 9'd150}, {1'b0, 4'd5, 9'd175},
    {1'b0, 4'd6, 9'd200}, {1'b0, 4'd7, 9'd250}, {1'b0, 4'd8, 9'd300},
    {1'b1, 4'd0, 9'd30},  {1'b1, 4'd1, 9'd40},  {1'b1, 4'd2, 9'd50},
    {1'b1, 4'd3, 9'd70},  {1'b1, 4'd4, 9'd100}, {1'b1, 4'd5, 9'd120},
    {1'b1, 4'd6, 9'd150},
    {1'b0, 4'd9, 9'd0},   {1'b1, 4'd7, 9'd0},   {1'b0, 4'd15, 9'd0}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] pinFs;
  logic pinSpreadEn, swSel, regKind, regSpreadEn;
  logic [3:0] regCode;
  logic signed [OFS_W-1:0] freqOffset;
  logic peakFlag;
  logic [1:0] fsReadback;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ssmod_profile #(.REF_KHZ(REF_KHZ), .MOD_KHZ(MOD_KHZ), .RAMP_LOG2(RAMP_LOG2), .OFS_W(OFS_W)) u_dut (
    .clk(clk), .rstN(rstN), .pinFs(pinFs), .pinSpreadEn(pinSpreadEn), .swSel(swSel),
    .regKind(regKind), .regCode(regCode), .regSpreadEn(regSpreadEn),
    .freqOffset(freqOffset), .peakFlag(peakFlag), .fsReadback(fsReadback)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitPeak(input string req, output bit got);
    got = 1'b0;
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      if (peakFlag) begin got = 1'b1; break; end
    end
    check(got, req, int'(got), 1);
  endtask

  // observe one full period starting at a peak
  task automatic measure(input int low, input int high, input int amt, input string req);
    bit got;
    int mn, mx, prev, cur, lastPk, nPk, badDelta, badGap;
    waitPeak(req, got);
    if (!got) return;
    cur = int'(freqOffset);
    mn = cur; mx = cur; prev = cur;
    lastPk = 0; nPk = 0; badDelta = 0; badGap = 0;
    for (int k = 1; k <= 2 * PER; k++) begin
      @(negedge clk);
      cur = int'(freqOffset);
      if (cur < mn) mn = cur;
      if (cur > mx) mx = cur;
      if (cur != prev) begin
        if ((cur - prev != amt) && (prev - cur != amt)) badDelta++;
        prev = cur;
      end
      if (peakFlag) begin
        nPk++;
        if (k - lastPk != PER) badGap++;
        lastPk = k;
      end
    end
    check(mn == low,  {req, " R4 minimum"}, mn, low);
    check(mx == high, {req, " R4 maximum"}, mx, high);
    check(badDelta == 0, "R5 step size", badDelta, 0);
    check(nPk == 2 && badGap == 0, "R5 peak spacing", badGap + (nPk == 2 ? 0 : 100), 0);
  endtask

  task automatic runRow(input logic [13:0] v);
    int amt, low, high;
    @(negedge clk);
    regSpreadEn = 1'b0;
    @(negedge clk);
    check(freqOffset == 0, "R6 disable zeroes offset", int'(freqOffset), 0);
    regKind = v[13];
    regCode = v[12:9];
    amt     = int'(v[8:0]);
    regSpreadEn = 1'b1;
    if (amt == 0) begin
      int nz = 0;
      for (int k = 0; k < 2 * PER; k++) begin
        @(negedge clk);
        if (freqOffset != 0) nz++;
      end
      check(nz == 0, "R4 unlisted code gives no spread", nz, 0);
    end else if (v[13] == 1'b0) begin
      low = -amt * N; high = 0;
      measure(low, high, amt, "R2");
    end else begin
      low = -amt * N / 2; high = amt * N / 2;
      measure(low, high, amt, "R3");
    end
  endtask

  initial begin
    int cur, prev, badOld, firstNew;
    bit seenZero, got;
    rstN = 1'b0; pinFs = 2'b10; pinSpreadEn = 1'b1; swSel = 1'b0;
    regKind = 1'b0; regCode = 4'd0; regSpreadEn = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(freqOffset == 0, "R1 reset offset", int'(freqOffset), 0);
    check(peakFlag == 1'b0, "R1 reset peak", int'(peakFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    pinFs = 2'b01; pinSpreadEn = 1'b0;
    @(negedge clk);
    check(fsReadback == 2'b10, "R8 readback held", int'(fsReadback), 2);

    // R1: first movement is downward
    got = 1'b0;
    for (int i = 0; i < 4 * DIV; i++) begin
      @(negedge clk);
      if (freqOffset != 0) begin got = 1'b1; break; end
    end
    check(got && freqOffset < 0, "R1 first step downward", int'(freqOffset), -80);

    // R7: hardware default 0.80 % down with latched enable (pin now low)
    measure(-80 * N, 0, 80, "R7");

    // table of shapes and codes under register control
    swSel = 1'b1;
    for (int r = 0; r < NVEC; r++) runRow(VEC[r]);

    // R6: disable in mid-ramp
    regKind = 1'b0; regCode = 4'd4; regSpreadEn = 1'b1;
    for (int i = 0; i < 4 * DIV; i++) @(negedge clk);
    check(freqOffset != 0, "R6 ramp running before disable", int'(freqOffset), -150);
    regSpreadEn = 1'b0;
    @(negedge clk);
    check(freqOffset == 0, "R6 mid-ramp disable", int'(freqOffset), 0);

    // R9: depth change in mid-ramp waits for the zero crossing
    regCode = 4'd2; regSpreadEn = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      if (freqOffset <= -1000) begin got = 1'b1; break; end
    end
    check(got, "R9 reached mid-ramp", int'(freqOffset), -1000);
    regCode = 4'd8;
    prev = int'(freqOffset); badOld = 0; seenZero = 1'b0; firstNew = 0;
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      cur = int'(freqOffset);
      if (cur != prev) begin
        if (seenZero) begin firstNew = cur - prev; break; end
        if ((cur - prev != 100) && (prev - cur != 100)) badOld++;
        if (cur == 0) seenZero = 1'b1;
        prev = cur;
      end
    end
    check(badOld == 0 && seenZero, "R9 old step kept until zero", badOld, 0);
    check(firstNew == -300, "R9 new step after zero", firstNew, -300);

    // R7 and R8: hardware source with enable pin low during reset
    swSel = 1'b0; pinFs = 2'b01; pinSpreadEn = 1'b0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    pinFs = 2'b11; pinSpreadEn = 1'b1;
    @(negedge clk);
    check(fsReadback == 2'b01, "R8 readback after second reset", int'(fsReadback), 1);
    begin
      int nz = 0;
      for (int k = 0; k < 2 * PER; k++) begin
        @(negedge clk);
        if (freqOffset != 0) nz++;
      end
      check(nz == 0, "R7 latched pin disable ignores later pin", nz, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule